// File: doc/BRIEF.md
# Thermal Sample Scheduler with Half-Weight Averaging

This block asks an on-die temperature sensor for a reading at a fixed, programmable spacing, and passes each returned reading either straight through or through a recursive average. The average gives the old result and the new reading equal weight. A management host reads the result from a register-style output. That output holds its value between updates, so the host can poll it at any rate.

The spacing between requests is counted in microseconds from an external one-microsecond tick strobe. The spacing runs from 82 µs to 20 ms and is 82 µs after reset. A new programmed spacing is picked up only when the current period ends. The averaging is on after reset and one configuration bit turns it off. The averaging weights are fixed. The first reading that the average sees loads the filter directly, so it never mixes with a stale value.

Top module: `therm_sample_sched`

## Requirements
- R1: During and after a synchronous active-low reset, `samp_req`, `temp_upd` and `temp_out` are 0, the active interval is 82 µs, and averaging is enabled. The first period after reset therefore lasts 82 ticks, whatever `ivl_cfg` holds.
- R2: `samp_req` is high for exactly one clock cycle, in the cycle after the clock edge that sampled the Nth `us_tick` of a period, where N is the active interval. The tick count then restarts from zero. Cycles without `us_tick` do not advance the count.
- R3: An `ivl_cfg` value above 20000 is used as 20000. For example, 32767 gives a 20000-tick period.
- R4: An `ivl_cfg` value below 82 is used as 82.
- R5: `ivl_cfg` is sampled only at the edge that ends a period. A change during a period leaves that period's length unchanged and sets the length of the next period.
- R6: With averaging on and the filter already loaded, a valid reading d changes the output to (temp_out + d) >> 1. The sum is formed one bit wider than the data, so it cannot overflow, and the fractional bit is dropped.
- R7: With averaging on, the first valid reading after reset, or after `filt_en` was low for at least one cycle, is stored unchanged.
- R8: With `filt_en` low, a valid reading is stored unchanged.
- R9: `temp_out` changes, and `temp_upd` pulses high for one cycle, only in the cycle after an edge that sampled `sens_valid` high. At all other times `temp_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| ivl_cfg | input | IVL_W (15) | Programmed capture interval in microseconds |
| filt_en | input | 1 | 1 selects averaging, 0 selects bypass |
| sens_valid | input | 1 | Sensor reading valid strobe |
| sens_data | input | TEMP_W (8) | Raw sensor reading |
| samp_req | output | 1 | One-cycle sample request to the sensor |
| temp_out | output | TEMP_W (8) | Stored (filtered or raw) temperature |
| temp_upd | output | 1 | One-cycle strobe when `temp_out` has been updated |

## Verification
The bench programs an interval in the middle of a period and measures both that period and the one after it. A design that applies the new interval at once would shorten the running period. The out-of-range settings 5 and 32767 are tested, and a design that skips clamping gives periods of 5 or 32767 ticks instead of 82 or 20000. On the filter side, the bench sends two full-scale readings to catch a sum that wraps without the extra bit. It also turns averaging off and on again to catch a filter that averages the first reading after re-enable with a stale value. Idle cycles between sensor strobes expose an output that drifts or re-strobes when no reading arrives.

// File: rtl/therm_pkg.sv
// Package: shared types and helpers for the thermal sample scheduler.
// Assumes interval values fit in 32 bits.
package therm_pkg;

    // Filter memory state: empty means the next reading loads directly.
    typedef enum logic {
        FS_EMPTY  = 1'b0,
        FS_PRIMED = 1'b1
    } filt_state_e;

    // Limit a requested interval to the legal window [lo, hi].
    function automatic int unsigned clamp_ivl(
        input int unsigned req,
        input int unsigned lo,
        input int unsigned hi
    );
        if (req > hi) begin
            return hi;
        end
        if (req < lo) begin
            return lo;
        end
        return req;
    endfunction

endpackage

// File: rtl/therm_ivl_timer.sv
// Module: interval timer. It counts microsecond ticks and raises a
// one-cycle sample request when the count reaches the active interval.
// The programmed interval is clamped and latched only at a period
// boundary, so a running period is never shortened.
// Assumes IVL_W is wide enough to hold MAX_IVL.
module therm_ivl_timer
    import therm_pkg::*;
#(
    parameter int IVL_W   = 15,
    parameter int DEF_IVL = 82,
    parameter int MIN_IVL = 82,
    parameter int MAX_IVL = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic [IVL_W-1:0] ivl_cfg,
    output logic             samp_req,
    output logic [IVL_W-1:0] cnt_o,
    output logic [IVL_W-1:0] ivl_act_o
);

    localparam logic [IVL_W-1:0] ONE     = IVL_W'(1);
    localparam logic [IVL_W-1:0] DEF_VAL = IVL_W'(DEF_IVL);

    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] ivl_act;
    logic [IVL_W-1:0] ivl_next;
    logic             period_end;

    // Clamp the programmed interval into the legal window.
    always_comb begin
        ivl_next = IVL_W'(clamp_ivl(32'(ivl_cfg), MIN_IVL, MAX_IVL));
    end

    // Detect the tick that completes the current period.
    always_comb begin
        period_end = us_tick && (cnt == (ivl_act - ONE));
    end

    // Advance the count, issue the request and reload the interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            ivl_act  <= DEF_VAL;
            samp_req <= 1'b0;
        end else begin
            samp_req <= period_end;
            if (period_end) begin
                cnt     <= '0;
                ivl_act <= ivl_next;
            end else if (us_tick) begin
                cnt <= cnt + ONE;
            end
        end
    end

    assign cnt_o     = cnt;
    assign ivl_act_o = ivl_act;

endmodule

// File: rtl/therm_half_avg.sv
// Module: half-weight recursive average with bypass. On each valid
// reading it stores either the raw value or (stored + raw) >> 1,
// computed one bit wider than the data so the sum cannot overflow.
// The filter reloads from the next reading after reset, or after
// filt_en has been low.
// Assumes sens_valid is a single-cycle strobe per reading.
module therm_half_avg
    import therm_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic              sens_valid,
    input  logic [TEMP_W-1:0] sens_data,
    output logic [TEMP_W-1:0] temp_out,
    output logic              temp_upd
);

    localparam int SUM_W = TEMP_W + 1;

    filt_state_e       st;
    logic [SUM_W-1:0]  sum;
    logic [TEMP_W-1:0] avg;
    logic [TEMP_W-1:0] nxt;

    // Form the widened sum and drop its fractional bit.
    always_comb begin
        sum = {1'b0, temp_out} + {1'b0, sens_data};
        avg = sum[SUM_W-1:1];
    end

    // Choose between a raw load and the averaged value.
    always_comb begin
        if (!filt_en || (st == FS_EMPTY)) begin
            nxt = sens_data;
        end else begin
            nxt = avg;
        end
    end

    // Update the stored value, the strobe and the filter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_out <= '0;
            temp_upd <= 1'b0;
            st       <= FS_EMPTY;
        end else begin
            temp_upd <= sens_valid;
            if (sens_valid) begin
                temp_out <= nxt;
            end
            if (!filt_en) begin
                st <= FS_EMPTY;
            end else if (sens_valid) begin
                st <= FS_PRIMED;
            end
        end
    end

endmodule

// File: rtl/therm_sample_sched.sv
// Module: top of the thermal sample scheduler. It joins the interval
// timer, which issues sensor requests, to the averaging stage, which
// holds the value the host reads.
// Assumes us_tick and sens_valid are synchronous to clk.
module therm_sample_sched #(
    parameter int TEMP_W  = 8,
    parameter int IVL_W   = 15,
    parameter int DEF_IVL = 82,
    parameter int MIN_IVL = 82,
    parameter int MAX_IVL = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [IVL_W-1:0]  ivl_cfg,
    input  logic              filt_en,
    input  logic              sens_valid,
    input  logic [TEMP_W-1:0] sens_data,
    output logic              samp_req,
    output logic [TEMP_W-1:0] temp_out,
    output logic              temp_upd
);

    logic [IVL_W-1:0] tmr_cnt;
    logic [IVL_W-1:0] ivl_act;

    // Request scheduling.
    therm_ivl_timer #(
        .IVL_W  (IVL_W),
        .DEF_IVL(DEF_IVL),
        .MIN_IVL(MIN_IVL),
        .MAX_IVL(MAX_IVL)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .ivl_cfg  (ivl_cfg),
        .samp_req (samp_req),
        .cnt_o    (tmr_cnt),
        .ivl_act_o(ivl_act)
    );

    // Reading conditioning and holding.
    therm_half_avg #(
        .TEMP_W(TEMP_W)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_en   (filt_en),
        .sens_valid(sens_valid),
        .sens_data (sens_data),
        .temp_out  (temp_out),
        .temp_upd  (temp_upd)
    );

endmodule

// File: rtl/therm_sample_chk.sv
// Module: assertion checker for therm_sample_sched, bound to the top.
// Observes ports and the timer's count and active interval.
module therm_sample_chk #(
    parameter int TEMP_W  = 8,
    parameter int IVL_W   = 15,
    parameter int MIN_IVL = 82,
    parameter int MAX_IVL = 20000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              us_tick,
    input logic              filt_en,
    input logic              sens_valid,
    input logic [TEMP_W-1:0] sens_data,
    input logic              samp_req,
    input logic [TEMP_W-1:0] temp_out,
    input logic              temp_upd,
    input logic [IVL_W-1:0]  tmr_cnt,
    input logic [IVL_W-1:0]  ivl_act
);

    logic past_ok;

    // Mark that one full cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_req |=> !samp_req);

    p_req_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        samp_req |-> $past(us_tick));

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cnt < ivl_act);

    p_ivl_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_act <= IVL_W'(MAX_IVL));

    p_ivl_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_act >= IVL_W'(MIN_IVL));

    p_ivl_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !samp_req) |-> $stable(ivl_act));

    p_avg_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && temp_upd && $past(filt_en)) |->
            ((temp_out >= (($past(temp_out) < $past(sens_data)) ? $past(temp_out) : $past(sens_data))) &&
             (temp_out <= (($past(temp_out) > $past(sens_data)) ? $past(temp_out) : $past(sens_data)))));

    p_bypass_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && temp_upd && !$past(filt_en)) |-> (temp_out == $past(sens_data)));

    p_upd_from_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        temp_upd |-> $past(sens_valid));

    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !temp_upd) |-> $stable(temp_out));

endmodule

bind therm_sample_sched therm_sample_chk #(
    .TEMP_W (TEMP_W),
    .IVL_W  (IVL_W),
    .MIN_IVL(MIN_IVL),
    .MAX_IVL(MAX_IVL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .filt_en   (filt_en),
    .sens_valid(sens_valid),
    .sens_data (sens_data),
    .samp_req  (samp_req),
    .temp_out  (temp_out),
    .temp_upd  (temp_upd),
    .tmr_cnt   (tmr_cnt),
    .ivl_act   (ivl_act)
);

// File: tb/therm_sample_sched_test.sv
module therm_sample_sched_test;

    localparam int TW = 8;
    localparam int IW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          us_tick = 1'b0;
    logic [IW-1:0] ivl_cfg = '0;
    logic          filt_en = 1'b1;
    logic          sens_valid = 1'b0;
    logic [TW-1:0] sens_data = '0;
    logic          samp_req;
    logic [TW-1:0] temp_out;
    logic          temp_upd;

    int nchk = 0;
    int nerr = 0;
    int exp_t = 0;
    bit primed = 1'b0;
    int exp_ivl = 82;

    therm_sample_sched uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick   (us_tick),
        .ivl_cfg   (ivl_cfg),
        .filt_en   (filt_en),
        .sens_valid(sens_valid),
        .sens_data (sens_data),
        .samp_req  (samp_req),
        .temp_out  (temp_out),
        .temp_upd  (temp_upd)
    );

    always #5 clk = ~clk;

    function automatic int lim(input int v);
        if (v > 20000) return 20000;
        if (v < 82) return 82;
        return v;
    endfunction

    function automatic int half_avg(input int a, input int b);
        return (a + b) / 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue ticks until a request appears; returns the tick count.
    task automatic run_period(input bit gaps, output int ticks);
        bit early;
        early = 1'b0;
        ticks = 0;
        while (ticks < 30000) begin
            if (gaps) begin
                for (int g = 0; g < int'($urandom_range(0, 2)); g++) begin
                    @(negedge clk);
                    if (samp_req) early = 1'b1;
                end
            end
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            ticks++;
            if (samp_req) break;
        end
        check(!early, "R2 request without tick", int'(early), 0);
        @(negedge clk);
        check(samp_req == 1'b0, "R2 strobe width", int'(samp_req), 0);
    endtask

    task automatic expect_period(input bit gaps, input int exp, input string tag);
        int got;
        run_period(gaps, got);
        check(got == exp, tag, got, exp);
    endtask

    // Send one reading and check the result and the strobe.
    task automatic send(input int d, input string tag);
        if (!filt_en) begin
            exp_t = d;
            primed = 1'b0;
        end else if (!primed) begin
            exp_t = d;
            primed = 1'b1;
        end else begin
            exp_t = half_avg(exp_t, d);
        end
        sens_valid = 1'b1;
        sens_data = TW'(d);
        @(negedge clk);
        sens_valid = 1'b0;
        sens_data = TW'($urandom);
        check(temp_upd == 1'b1, "R9 update strobe", int'(temp_upd), 1);
        check(int'(temp_out) == exp_t, tag, int'(temp_out), exp_t);
    endtask

    task automatic idle_hold(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(temp_upd == 1'b0, "R9 no strobe when idle", int'(temp_upd), 0);
            check(int'(temp_out) == exp_t, "R9 hold when idle", int'(temp_out), exp_t);
        end
    endtask

    task automatic set_filt(input bit en);
        filt_en = en;
        if (!en) primed = 1'b0;
    endtask

    initial begin
        #1_500_000;
        nerr++;
        $display("FAIL R2 watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int nxt;
        void'($urandom(32'd4242));
        ivl_cfg = IW'(200);
        repeat (3) @(negedge clk);
        check(samp_req == 1'b0, "R1 reset samp_req", int'(samp_req), 0);
        check(temp_upd == 1'b0, "R1 reset temp_upd", int'(temp_upd), 0);
        check(temp_out == '0, "R1 reset temp_out", int'(temp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Interval scheduling.
        repeat (20) @(negedge clk);
        check(samp_req == 1'b0, "R2 no ticks no request", int'(samp_req), 0);
        expect_period(1'b1, 82, "R1 default first period");
        ivl_cfg = IW'(120);
        expect_period(1'b1, 200, "R5 running period kept");
        ivl_cfg = IW'(5);
        expect_period(1'b1, 120, "R5 new interval next period");
        ivl_cfg = IW'(32767);
        expect_period(1'b1, 82, "R4 low value clamped");
        ivl_cfg = IW'(150);
        expect_period(1'b0, 20000, "R3 high value clamped");
        exp_ivl = 150;
        for (int k = 0; k < 5; k++) begin
            nxt = int'($urandom_range(60, 400));
            ivl_cfg = IW'(nxt);
            expect_period(1'b1, exp_ivl, "R2 random period");
            exp_ivl = lim(nxt);
        end
        expect_period(1'b1, exp_ivl, "R2 random period last");

        // Filter behaviour.
        send(100, "R7 first reading after reset");
        send(50, "R6 average");
        send(51, "R6 average truncation");
        idle_hold(3);
        send(255, "R6 average toward full scale");
        send(255, "R6 average toward full scale");
        send(255, "R6 average toward full scale");
        set_filt(1'b0);
        send(255, "R8 bypass full scale");
        send(254, "R8 bypass raw");
        set_filt(1'b1);
        send(255, "R6 no overflow full scale");
        set_filt(1'b0);
        send(10, "R8 bypass");
        set_filt(1'b1);
        send(200, "R7 first reading after re-enable");
        send(0, "R6 average to zero");
        set_filt(1'b0);
        @(negedge clk);
        set_filt(1'b1);
        @(negedge clk);
        send(77, "R7 reload after off window");
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 7) == 0) set_filt(~filt_en);
            send(int'($urandom_range(0, 255)), filt_en ? "R6 random average" : "R8 random bypass");
            if ($urandom_range(0, 3) == 0) idle_hold(int'($urandom_range(1, 3)));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule